// File: doc/BRIEF.md
# Scratchpad Write Protection Engine

This block is the staging path of a serial EEPROM slave that sits behind a byte-level link layer. The master opens a transaction with a command byte. A write-scratchpad transaction loads a 16-bit target address and then a run of data bytes. The bytes land in an 8-byte scratchpad row, starting at the offset given by the low three address bits. Before a byte is stored it is combined with the memory byte at the same address. The combination depends on the protection setting of the page that holds the target address: the byte passes unchanged, the stored byte replaces it, or the two are ANDed to emulate one-time-programmable cells.

A read-scratchpad transaction returns, in this order, the address, the ending-offset/status byte, the staged bytes and an inverted CRC16 that covers everything in the transaction. A copy transaction must echo the address and status byte exactly. When it does, the whole 8-byte row is written to the backing memory, one byte per cycle in which the memory reports ready. A bus reset from the link layer ends any command except a copy that has already started.

Top module: `spw_engine`

## Requirements
- R1: After reset, tx_valid, mem_we, cpy_done and cpy_ok are low, and the target address, status byte and all scratchpad bytes are zero.
- R2: Command 0x0F, then address low byte, then address high byte, then data: each data byte is stored at the next scratchpad offset, starting from address bits 2:0. The ending offset (status bits 2:0) follows the last stored byte.
- R3: Data bytes that arrive after the byte at offset 7 has been stored are ignored. The ending offset stays 7.
- R4: When the target page (address bits 6:5) has its write-protect input set, the memory byte at the target address is stored in place of the received byte.
- R5: When the target page has its emulation input set and its write-protect input clear, the bitwise AND of the received byte and the memory byte is stored. Write-protect takes priority when both inputs are set.
- R6: The protection inputs are sampled when the address high byte arrives. Later changes to them have no effect on that write.
- R7: After command 0xAA, each tx_req returns the next byte of this sequence: address low, address high, status byte, scratchpad bytes from offset address[2:0] through the ending offset, CRC low byte, CRC high byte, then 0xFF for every further request.
- R8: The CRC is CRC16 with polynomial x^16+x^15+x^2+1, initial value 0, bits processed LSB first. It runs over the command byte and every byte sent before it. Both CRC bytes are sent bit-inverted.
- R9: bus_rst ends a read (or any command other than a running copy) at once. A following tx_req returns 0xFF, and a new read starts again from the address low byte.
- R10: A bus_rst with rx_frag high, arriving while a write is accepting data, sets the partial flag (status bit 5). The flag is cleared when the next write's address high byte arrives.
- R11: Command 0x55 followed by address low, address high and status bytes that all equal the stored values, with the partial flag clear, writes scratchpad bytes 0..7 to row address[6:3] in offset order. Each byte is written only in a cycle with mem_ready high. cpy_done then pulses with cpy_ok high. Any mismatch, or a set partial flag, gives a cpy_done pulse with cpy_ok low and no memory write.
- R12: tx_valid rises exactly one cycle after a tx_req cycle. A request outside a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset seen by the link layer, one cycle |
| rx_frag | input | 1 | Qualifies bus_rst: an incomplete byte was pending |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Link layer asks for the next byte to send |
| tx_valid | output | 1 | tx_byte is valid, one cycle after tx_req |
| tx_byte | output | 8 | Byte to send |
| page_wp | input | 4 | Per-page write-protect settings |
| page_ep | input | 4 | Per-page AND-emulation settings |
| mem_raddr | output | 7 | Memory read address (combinational read) |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory can accept a write this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 7 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| cpy_done | output | 1 | Copy finished or rejected, one cycle |
| cpy_ok | output | 1 | Result of the last copy, held |

## Verification
A wrong merge selection or a wrong sampled protection setting leaves a bad byte in the scratchpad. That byte shows in the next read, and the CRC bytes after it are wrong too. A stale read pointer or phase shows as a wrong or shifted byte on the very next tx_req after the fault, and a missed bus reset shows as a non-0xFF reply on the first request after it. A faulty status register shows twice: in the status byte of a read, and in a copy whose echo should match but is rejected, so that cpy_done arrives with cpy_ok low and the memory row is left unchanged.

// File: rtl/spw_pkg.sv
package spw_pkg;

  localparam logic [7:0] CMD_WRITE = 8'h0F;
  localparam logic [7:0] CMD_READ  = 8'hAA;
  localparam logic [7:0] CMD_COPY  = 8'h55;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_CMD, ST_WA1, ST_WA2, ST_WDAT, ST_RD,
    ST_CA1, ST_CA2, ST_CES, ST_CPY, ST_HALT
  } st_t;

  typedef enum logic [2:0] {
    RP_TA1, RP_TA2, RP_ES, RP_DAT, RP_CLO, RP_CHI, RP_FILL
  } rp_t;

  // One byte through the reflected x^16+x^15+x^2+1 register, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

endpackage

// File: rtl/spw_merge.sv
module spw_merge (
  input  logic [7:0] rx_data,
  input  logic [7:0] stored,
  input  logic       wp,
  input  logic       ep,
  output logic [7:0] merged
);
  always_comb begin
    if (wp)      merged = stored;
    else if (ep) merged = rx_data & stored;
    else         merged = rx_data;
  end
endmodule

// File: rtl/spw_store.sv
module spw_store #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [7:0]       rd_a,
  output logic [7:0]       rd_b
);
  localparam int NB = 1 << IDX_W;

  logic [7:0] cells [NB];

  generate
    for (genvar g = 0; g < NB; g++) begin : g_byte
      logic [7:0] q;
      logic       en;
      assign en = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wr_data;
      end
      assign cells[g] = q;
    end
  endgenerate

  assign rd_a = cells[rd_idx_a];
  assign rd_b = cells[rd_idx_b];
endmodule

// File: rtl/spw_crc16.sv
module spw_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import spw_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (ld)      crc_d = crc16_step(16'h0000, din);
    else if (en) crc_d = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/spw_copier.sv
module spw_copier #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mem_ready,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = '1;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && mem_ready) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign we   = busy_q && mem_ready;
  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/spw_engine.sv
module spw_engine #(
  parameter int MEM_AW  = 7,
  parameter int PAGE_AW = 5,
  parameter int ROW_AW  = 3,
  localparam int NPAGE  = 1 << (MEM_AW - PAGE_AW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              rx_frag,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic [NPAGE-1:0]  page_wp,
  input  logic [NPAGE-1:0]  page_ep,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              cpy_done,
  output logic              cpy_ok
);
  import spw_pkg::*;

  localparam int PG_W = MEM_AW - PAGE_AW;
  localparam int RW_W = MEM_AW - ROW_AW;
  localparam logic [ROW_AW-1:0] LAST_IDX = '1;
  localparam int PF_BIT = 5;

  // State registers and their next values
  st_t               st_q, st_d;
  logic [15:0]       ta_q, ta_d;
  logic [ROW_AW-1:0] end_q, end_d;
  logic              pf_q, pf_d;
  logic [ROW_AW-1:0] cnt_q, cnt_d;
  logic              wp_q, wp_d, ep_q, ep_d;
  logic              mok_q, mok_d;
  rp_t               rp_q, rp_d;
  logic [ROW_AW-1:0] ridx_q, ridx_d;
  logic              txv_q, txv_d;
  logic [7:0]        txb_q, txb_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;

  // Internal strobes
  logic              sp_we, crc_ld, crc_en, cp_start, cp_fail;
  logic              cp_we, cp_done;
  logic [ROW_AW-1:0] cp_idx;
  logic [7:0]        merged, sp_rd_a, sp_rd_b, crc_din;
  logic [15:0]       crc;
  logic [15:0]       ta_next;
  logic [PG_W-1:0]   pg_sel;
  logic [RW_W-1:0]   row;
  logic [7:0]        es_byte;

  assign ta_next = {rx_byte, ta_q[7:0]};
  assign pg_sel  = ta_next[MEM_AW-1:PAGE_AW];
  assign row     = ta_q[MEM_AW-1:ROW_AW];

  always_comb begin
    es_byte                 = '0;
    es_byte[PF_BIT]         = pf_q;
    es_byte[ROW_AW-1:0]     = end_q;
  end

  spw_merge u_merge (
    .rx_data (rx_byte),
    .stored  (mem_rdata),
    .wp      (wp_q),
    .ep      (ep_q),
    .merged  (merged)
  );

  spw_store #(.IDX_W(ROW_AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sp_we),
    .wr_idx   (cnt_q),
    .wr_data  (merged),
    .rd_idx_a (ridx_q),
    .rd_idx_b (cp_idx),
    .rd_a     (sp_rd_a),
    .rd_b     (sp_rd_b)
  );

  assign crc_din = crc_ld ? rx_byte : txb_d;

  spw_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (crc_ld),
    .en    (crc_en),
    .din   (crc_din),
    .crc   (crc)
  );

  spw_copier #(.IDX_W(ROW_AW)) u_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cp_start),
    .mem_ready (mem_ready),
    .we        (cp_we),
    .idx       (cp_idx),
    .done      (cp_done)
  );

  // Command / write / copy control
  always_comb begin
    st_d     = st_q;
    ta_d     = ta_q;
    end_d    = end_q;
    pf_d     = pf_q;
    cnt_d    = cnt_q;
    wp_d     = wp_q;
    ep_d     = ep_q;
    mok_d    = mok_q;
    sp_we    = 1'b0;
    crc_ld   = 1'b0;
    cp_start = 1'b0;
    cp_fail  = 1'b0;
    if (bus_rst) begin
      if (st_q == ST_WDAT && rx_frag) pf_d = 1'b1;
      if (st_q != ST_CPY)             st_d = ST_CMD;
    end else if (rx_valid) begin
      case (st_q)
        ST_CMD: begin
          case (rx_byte)
            CMD_WRITE: st_d = ST_WA1;
            CMD_READ: begin
              st_d   = ST_RD;
              crc_ld = 1'b1;
            end
            CMD_COPY:  st_d = ST_CA1;
            default:   st_d = ST_HALT;
          endcase
        end
        ST_WA1: begin
          ta_d[7:0] = rx_byte;
          st_d      = ST_WA2;
        end
        ST_WA2: begin
          ta_d  = ta_next;
          cnt_d = ta_q[ROW_AW-1:0];
          end_d = ta_q[ROW_AW-1:0];
          pf_d  = 1'b0;
          wp_d  = page_wp[pg_sel];
          ep_d  = page_ep[pg_sel];
          st_d  = ST_WDAT;
        end
        ST_WDAT: begin
          sp_we = 1'b1;
          end_d = cnt_q;
          if (cnt_q == LAST_IDX) st_d = ST_HALT;
          else                   cnt_d = cnt_q + 1'b1;
        end
        ST_CA1: begin
          mok_d = (rx_byte == ta_q[7:0]);
          st_d  = ST_CA2;
        end
        ST_CA2: begin
          mok_d = mok_q && (rx_byte == ta_q[15:8]);
          st_d  = ST_CES;
        end
        ST_CES: begin
          if (mok_q && (rx_byte == es_byte) && !pf_q) begin
            cp_start = 1'b1;
            st_d     = ST_CPY;
          end else begin
            cp_fail = 1'b1;
            st_d    = ST_HALT;
          end
        end
        default: ;
      endcase
    end
    if (st_q == ST_CPY && cp_done) st_d = ST_HALT;
  end

  // Transmit sequencing for the read command
  always_comb begin
    rp_d   = rp_q;
    ridx_d = ridx_q;
    txv_d  = 1'b0;
    txb_d  = txb_q;
    crc_en = 1'b0;
    if (crc_ld) rp_d = RP_TA1;
    if (tx_req) begin
      txv_d = 1'b1;
      txb_d = IDLE_BYTE;
      if (st_q == ST_RD && !bus_rst) begin
        case (rp_q)
          RP_TA1: begin
            txb_d  = ta_q[7:0];
            crc_en = 1'b1;
            rp_d   = RP_TA2;
          end
          RP_TA2: begin
            txb_d  = ta_q[15:8];
            crc_en = 1'b1;
            rp_d   = RP_ES;
          end
          RP_ES: begin
            txb_d  = es_byte;
            crc_en = 1'b1;
            ridx_d = ta_q[ROW_AW-1:0];
            rp_d   = RP_DAT;
          end
          RP_DAT: begin
            txb_d  = sp_rd_a;
            crc_en = 1'b1;
            if (ridx_q == end_q) rp_d = RP_CLO;
            else                 ridx_d = ridx_q + 1'b1;
          end
          RP_CLO: begin
            txb_d = ~crc[7:0];
            rp_d  = RP_CHI;
          end
          RP_CHI: begin
            txb_d = ~crc[15:8];
            rp_d  = RP_FILL;
          end
          default: txb_d = IDLE_BYTE;
        endcase
      end
    end
  end

  // Copy result
  always_comb begin
    done_d = cp_fail || cp_done;
    ok_d   = done_d ? cp_done : ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      ta_q   <= '0;
      end_q  <= '0;
      pf_q   <= 1'b0;
      cnt_q  <= '0;
      wp_q   <= 1'b0;
      ep_q   <= 1'b0;
      mok_q  <= 1'b0;
      rp_q   <= RP_TA1;
      ridx_q <= '0;
      txv_q  <= 1'b0;
      txb_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ta_q   <= ta_d;
      end_q  <= end_d;
      pf_q   <= pf_d;
      cnt_q  <= cnt_d;
      wp_q   <= wp_d;
      ep_q   <= ep_d;
      mok_q  <= mok_d;
      rp_q   <= rp_d;
      ridx_q <= ridx_d;
      txv_q  <= txv_d;
      txb_q  <= txb_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign mem_raddr = {row, cnt_q};
  assign mem_we    = cp_we;
  assign mem_waddr = {row, cp_idx};
  assign mem_wdata = sp_rd_b;
  assign tx_valid  = txv_q;
  assign tx_byte   = txb_q;
  assign cpy_done  = done_q;
  assign cpy_ok    = ok_q;
endmodule

// File: rtl/spw_engine_chk.sv
module spw_engine_chk #(
  parameter int MEM_AW = 7,
  parameter int ROW_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_req,
  input logic              tx_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_waddr,
  input logic              cpy_done,
  input logic              cpy_ok
);
  // R12: a transmitted byte always answers a request from the cycle before
  assert_tx_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));

  // R11: memory is written only while it reports ready
  assert_we_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_ready);

  // R11: back-to-back writes stay in one row and step the offset by one
  assert_row_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_waddr[MEM_AW-1:ROW_AW] == $past(mem_waddr[MEM_AW-1:ROW_AW])) &&
      (mem_waddr[ROW_AW-1:0] == $past(mem_waddr[ROW_AW-1:0]) + 1'b1));

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_done |=> !cpy_done);

  // R11: the result flag moves only together with a completion pulse
  assert_ok_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpy_ok != $past(cpy_ok)) |-> cpy_done);
endmodule

bind spw_engine spw_engine_chk #(.MEM_AW(MEM_AW), .ROW_AW(ROW_AW)) u_spw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_req    (tx_req),
  .tx_valid  (tx_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .cpy_done  (cpy_done),
  .cpy_ok    (cpy_ok)
);

// File: tb/spw_engine_bench.sv
`timescale 1ns/1ps
module spw_engine_bench;

  logic       clk;
  logic       rst_n;
  logic       bus_rst, rx_frag, rx_valid, tx_req;
  logic [7:0] rx_byte;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic [3:0] page_wp, page_ep;
  logic [6:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rdata, mem_wdata;
  logic       mem_ready, mem_we;
  logic       cpy_done, cpy_ok;

  int checks = 0;
  int failures = 0;
  int wcount = 0;
  bit stall_mode = 0;
  bit finished = 0;

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];

  // Reference state kept from the requirements
  logic [15:0] m_ta;
  logic [2:0]  m_end;
  logic        m_pf;
  logic [7:0]  m_sp [8];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  spw_engine u_spw_engine (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_frag(rx_frag),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .page_wp(page_wp),
    .page_ep(page_ep), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .cpy_done(cpy_done), .cpy_ok(cpy_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_raddr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_waddr] <= mem_wdata;
      wcount <= wcount + 1;
    end
  end

  always @(negedge clk) mem_ready <= stall_mode ? ~mem_ready : 1'b1;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected byte", {8'h0, tx_byte}, 16'hDEAD);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {8'h0, tx_byte}, {8'h0, e});
      end
    end
  end

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_es();
    return {2'b00, m_pf, 2'b00, m_end};
  endfunction

  task automatic expect_push(logic [7:0] b, string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pull();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic bus_pulse(bit frag);
    @(negedge clk); bus_rst = 1'b1; rx_frag = frag;
    @(negedge clk); bus_rst = 1'b0; rx_frag = 1'b0;
  endtask

  task automatic do_write(logic [15:0] a, int n, logic [7:0] d [8], int flip);
    bit wp, ep, full;
    int cnt;
    bus_pulse(0);
    send(8'h0F); send(a[7:0]); send(a[15:8]);
    wp = page_wp[a[6:5]]; ep = page_ep[a[6:5]];
    if (flip >= 0) begin
      page_wp[flip] = ~page_wp[flip];
      page_ep[flip] = ~page_ep[flip];
    end
    m_ta = a; m_end = a[2:0]; m_pf = 1'b0;
    cnt = a[2:0]; full = 0;
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] s = exp_mem[{a[6:3], 3'(cnt)}];
      send(d[k]);
      if (!full) begin
        m_sp[cnt] = wp ? s : (ep ? (d[k] & s) : d[k]);
        m_end = 3'(cnt);
        if (cnt == 7) full = 1; else cnt++;
      end
    end
  endtask

  task automatic do_read(string tag, int stop_after);
    logic [7:0] seq [$];
    logic [15:0] c;
    int n;
    bus_pulse(0);
    send(8'hAA);
    seq.push_back(m_ta[7:0]);
    seq.push_back(m_ta[15:8]);
    seq.push_back(ref_es());
    for (int o = int'(m_ta[2:0]); o <= int'(m_end); o++) seq.push_back(m_sp[o]);
    c = ref_crc(16'h0, 8'hAA);
    foreach (seq[i]) c = ref_crc(c, seq[i]);
    seq.push_back(~c[7:0]);
    seq.push_back(~c[15:8]);
    seq.push_back(8'hFF);
    n = (stop_after < 0) ? seq.size() : stop_after;
    for (int k = 0; k < n; k++) begin
      expect_push(seq[k], tag);
      pull();
    end
    if (stop_after >= 0) begin
      bus_pulse(0);
      expect_push(8'hFF, "R9 request after bus reset");
      pull();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_copy(string tag, logic [15:0] a, logic [7:0] es, bit exp_ok);
    int w0, t;
    w0 = wcount;
    bus_pulse(0);
    send(8'h55); send(a[7:0]); send(a[15:8]); send(es);
    t = 0;
    while (!cpy_done && t < 100) begin
      @(negedge clk); t++;
    end
    check({tag, " done pulse"}, {15'h0, cpy_done}, 16'h1);
    check({tag, " ok flag"}, {15'h0, cpy_ok}, {15'h0, exp_ok});
    repeat (2) @(negedge clk);
    if (exp_ok) for (int j = 0; j < 8; j++) exp_mem[{m_ta[6:3], 3'(j)}] = m_sp[j];
    check({tag, " write count"}, 16'(wcount - w0), exp_ok ? 16'd8 : 16'd0);
    for (int j = 0; j < 8; j++)
      check({tag, " memory row"}, {8'h0, mem[{a[6:3], 3'(j)}]}, {8'h0, exp_mem[{a[6:3], 3'(j)}]});
  endtask

  initial begin
    #900000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rst = 0; rx_frag = 0; rx_valid = 0; rx_byte = 0; tx_req = 0;
    page_wp = 4'b1010; page_ep = 4'b1100; mem_ready = 1'b1;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = mem[i];
    end
    m_ta = 0; m_end = 0; m_pf = 0;
    for (int i = 0; i < 8; i++) m_sp[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values at the ports
    check("R1 tx_valid", {15'h0, tx_valid}, 16'h0);
    check("R1 mem_we", {15'h0, mem_we}, 16'h0);
    check("R1 cpy_done", {15'h0, cpy_done}, 16'h0);
    check("R1 cpy_ok", {15'h0, cpy_ok}, 16'h0);
    // R12 request outside a read
    expect_push(8'hFF, "R12 idle request");
    pull();
    do_read("R1 read after reset", -1);

    // R2 plain page 0
    do_write(16'h0002, 3, '{8'hA1, 8'hB2, 8'hC3, 0, 0, 0, 0, 0}, -1);
    do_read("R2 R7 R8 plain write", -1);

    // R4 protected page 1
    do_write(16'h0028, 4, '{8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0, 0}, -1);
    do_read("R4 protected page", -1);

    // R5 emulation page 2
    do_write(16'h0041, 2, '{8'hF0, 8'h3C, 0, 0, 0, 0, 0, 0}, -1);
    do_read("R5 AND page", -1);

    // R5 both set on page 3: protect wins
    do_write(16'h0063, 2, '{8'h00, 8'h00, 0, 0, 0, 0, 0, 0}, -1);
    do_read("R5 priority page", -1);

    // R3 overflow past offset 7
    do_write(16'h0006, 4, '{8'h5A, 8'hA5, 8'h77, 8'h88, 0, 0, 0, 0}, -1);
    do_read("R3 row end", -1);

    // R6 protection change after address high byte
    do_write(16'h0010, 2, '{8'h96, 8'h69, 0, 0, 0, 0, 0, 0}, 0);
    page_wp[0] = 1'b0; page_ep[0] = 1'b0;
    do_read("R6 sampled protection", -1);

    // R9 aborted read, then a full one
    do_read("R9 partial read", 4);
    do_read("R9 read restarts", -1);

    // R10 partial flag, and copy rejected because of it
    do_write(16'h0000, 2, '{8'hDE, 8'hAD, 0, 0, 0, 0, 0, 0}, -1);
    bus_pulse(1);
    m_pf = 1'b1;
    do_read("R10 partial flag", -1);
    do_copy("R10 R11 copy with flag", m_ta, ref_es(), 1'b0);

    // R11 successful copy with memory stalls
    do_write(16'h0018, 8, '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF}, -1);
    stall_mode = 1;
    do_copy("R11 copy ok", m_ta, ref_es(), 1'b1);
    stall_mode = 0;

    // R11 mismatched address echo
    do_write(16'h0020, 1, '{8'h42, 0, 0, 0, 0, 0, 0, 0}, -1);
    do_copy("R11 copy mismatch", 16'h0021, ref_es(), 1'b0);

    repeat (4) @(negedge clk);
    check("R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule